// File: doc/BRIEF.md
# Read-to-clear interrupt status register

This block holds the one-byte interrupt cause for a paravirtual PCI function that signals through a legacy interrupt pin. Two single-cycle event inputs mark queue activity and configuration changes. Each event sets its own sticky bit in the byte. A read strobe returns the byte on the next cycle and clears it in the same step. Because of that clear, a driver reading the cause is also acknowledging the interrupt.

The block produces two outputs from the byte. The first is the summary Interrupt Status flag that the PCI Status register reports. The second is the level on the interrupt pin. Both are suppressed while message-signalled interrupts are enabled. The pin is also suppressed by the interrupt-disable bit of the command register. Address decode sits outside this block. Any byte access that the decoder routes here arrives as one read strobe, so the byte has no alignment constraint.

When an event arrives in the same cycle as a clearing read, the read returns the old byte and the new event's bit stays set. No event is ever lost.

Top module: `irq_cause_byte`

## Requirements
- R1: After a synchronous active-low reset, the field reads 0x00, `rd_data` is 0x00, and both `pci_int_status` and `intx_out` are low.
- R2: A pulse on `queue_evt` sets bit 0 (value 0x01), and a pulse on `cfg_evt` sets bit 1 (value 0x02). Bits 7 to 2 always read as zero.
- R3: Bits are sticky and do not count. Several events of one kind before a read leave that bit set once, and a second read returns 0x00.
- R4: `rd_en` is sampled at a rising edge. After that edge, `rd_data` holds the field value from before the edge, and the field is cleared.
- R5: While `msix_en` is low, `pci_int_status` is high exactly when any bit of the field is set. It rises in the cycle after an event.
- R6: `intx_out` follows `pci_int_status` while `intx_disable` is low, and stays low while `intx_disable` is high.
- R7: A read with no event in the same cycle drops `intx_out` and `pci_int_status` in the following cycle.
- R8: While `msix_en` is high, `pci_int_status` and `intx_out` are low, even when bits are set.
- R9: When an event coincides with a read, the read returns the old value and the event's bit is set afterwards. This also holds when the bit was already set.
- R10: Reads while `msix_en` is high still return and clear the field, so clearing `msix_en` afterwards raises no interrupt.
- R11: `rd_data` changes only at an edge where `rd_en` was high, or on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| queue_evt | input | 1 | Queue activity event pulse |
| cfg_evt | input | 1 | Configuration change event pulse |
| rd_en | input | 1 | Read strobe for the status byte; clears the field |
| rd_data | output | 8 | Byte returned one cycle after the strobe |
| msix_en | input | 1 | Message-signalled interrupts enabled |
| intx_disable | input | 1 | Command register interrupt-disable bit |
| pci_int_status | output | 1 | Interrupt Status flag for the PCI Status register |
| intx_out | output | 1 | Legacy interrupt pin level, active high |

## Verification
The hardest case to reach is an event landing in exactly the cycle where a read clears the field. The directed race task creates it by holding the read strobe and an event input high for the same single cycle. It does this once with a different bit and once with the bit already set. It then reads again to show that the event survived the clear. A second awkward case is a stale cause left behind while message-signalled interrupts are on. That task sets a bit under `msix_en`, reads it away, and then drops `msix_en` to show that the pin stays quiet.

// File: rtl/irq_cause_byte.sv
module irq_cause_byte #(
  parameter int WIDTH = 8,
  parameter int Q_BIT = 0,
  parameter int C_BIT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             queue_evt,
  input  logic             cfg_evt,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  input  logic             msix_en,
  input  logic             intx_disable,
  output logic             pci_int_status,
  output logic             intx_out
);
  localparam logic [WIDTH-1:0] Q_MASK = WIDTH'(1) << Q_BIT;
  localparam logic [WIDTH-1:0] C_MASK = WIDTH'(1) << C_BIT;

  logic [WIDTH-1:0] cause;
  logic [WIDTH-1:0] set_bits;
  logic [WIDTH-1:0] kept;

  assign set_bits = (queue_evt ? Q_MASK : '0) | (cfg_evt ? C_MASK : '0);
  assign kept     = rd_en ? '0 : cause;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause   <= '0;
      rd_data <= '0;
    end else begin
      cause <= kept | set_bits;
      if (rd_en) rd_data <= cause;
    end
  end

  assign pci_int_status = (|cause) & ~msix_en;
  assign intx_out       = pci_int_status & ~intx_disable;
endmodule

module irq_cause_byte_chk #(
  parameter int WIDTH = 8,
  parameter int Q_BIT = 0,
  parameter int C_BIT = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             queue_evt,
  input logic             cfg_evt,
  input logic             rd_en,
  input logic [WIDTH-1:0] rd_data,
  input logic             msix_en,
  input logic             intx_disable,
  input logic             pci_int_status,
  input logic             intx_out,
  input logic [WIDTH-1:0] cause
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (rd_data == '0 && cause == '0)); // R1
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (rd_data >> 2) == '0); // R2
  AST_QUEUE_KEEP: assert property (@(posedge clk) disable iff (!rst_n) rst_n && queue_evt |=> cause[Q_BIT]); // R9
  AST_CFG_KEEP: assert property (@(posedge clk) disable iff (!rst_n) rst_n && cfg_evt |=> cause[C_BIT]); // R9
  AST_READ_DATA: assert property (@(posedge clk) disable iff (!rst_n) rst_n && rd_en |=> rd_data == $past(cause)); // R4
  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) rst_n && rd_en && !queue_evt && !cfg_evt |=> cause == '0); // R4
  AST_STATUS_RISE: assert property (@(posedge clk) disable iff (!rst_n) rst_n && (queue_evt || cfg_evt) |=> (pci_int_status || msix_en)); // R5
  AST_PIN_MASK: assert property (@(posedge clk) disable iff (!rst_n) intx_disable |-> !intx_out); // R6
  AST_PIN_DROP: assert property (@(posedge clk) disable iff (!rst_n) rst_n && rd_en && !queue_evt && !cfg_evt |=> !intx_out); // R7
  AST_MSIX_QUIET: assert property (@(posedge clk) disable iff (!rst_n) msix_en |-> (!pci_int_status && !intx_out)); // R8
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) rst_n && !rd_en |=> $stable(rd_data)); // R11
endmodule

bind irq_cause_byte irq_cause_byte_chk #(.WIDTH(WIDTH), .Q_BIT(Q_BIT), .C_BIT(C_BIT)) chk_i (
  .clk(clk), .rst_n(rst_n), .queue_evt(queue_evt), .cfg_evt(cfg_evt), .rd_en(rd_en),
  .rd_data(rd_data), .msix_en(msix_en), .intx_disable(intx_disable),
  .pci_int_status(pci_int_status), .intx_out(intx_out), .cause(cause)
);

// File: tb/irq_cause_byte_tb_top.sv
`timescale 1ns/1ps
module irq_cause_byte_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       queue_evt = 1'b0;
  logic       cfg_evt = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       msix_en = 1'b0;
  logic       intx_disable = 1'b0;
  logic       pci_int_status;
  logic       intx_out;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  irq_cause_byte dut_i (
    .clk(clk), .rst_n(rst_n), .queue_evt(queue_evt), .cfg_evt(cfg_evt),
    .rd_en(rd_en), .rd_data(rd_data), .msix_en(msix_en), .intx_disable(intx_disable),
    .pci_int_status(pci_int_status), .intx_out(intx_out)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_q();
    queue_evt = 1'b1; tick(); queue_evt = 1'b0;
  endtask

  task automatic pulse_c();
    cfg_evt = 1'b1; tick(); cfg_evt = 1'b0;
  endtask

  task automatic do_read();
    rd_en = 1'b1; tick(); rd_en = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; tick(); tick();
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 status", {7'd0, pci_int_status}, 8'h00);
    chk("R1 intx", {7'd0, intx_out}, 8'h00);
    rst_n = 1'b1;
    pulse_q();
    rst_n = 1'b0; tick(); rst_n = 1'b1;
    chk("R1 status after reset", {7'd0, pci_int_status}, 8'h00);
    do_read();
    chk("R1 field cleared by reset", rd_data, 8'h00);
  endtask

  task automatic t_queue();
    pulse_q();
    chk("R5 status on queue", {7'd0, pci_int_status}, 8'h01);
    chk("R6 intx on queue", {7'd0, intx_out}, 8'h01);
    do_read();
    chk("R2 queue bit", rd_data, 8'h01);
    chk("R7 intx drops", {7'd0, intx_out}, 8'h00);
    chk("R7 status drops", {7'd0, pci_int_status}, 8'h00);
  endtask

  task automatic t_cfg();
    pulse_c();
    chk("R5 status on cfg", {7'd0, pci_int_status}, 8'h01);
    do_read();
    chk("R2 cfg bit", rd_data, 8'h02);
    do_read();
    chk("R4 field cleared", rd_data, 8'h00);
  endtask

  task automatic t_sticky();
    pulse_q(); pulse_q(); pulse_q(); pulse_c(); pulse_c();
    do_read();
    chk("R3 sticky both", rd_data, 8'h03);
    do_read();
    chk("R3 second read", rd_data, 8'h00);
  endtask

  task automatic t_mask();
    intx_disable = 1'b1;
    pulse_q();
    chk("R6 masked status", {7'd0, pci_int_status}, 8'h01);
    chk("R6 masked pin", {7'd0, intx_out}, 8'h00);
    intx_disable = 1'b0; #1;
    chk("R6 unmasked pin", {7'd0, intx_out}, 8'h01);
    do_read();
    chk("R6 read after mask", rd_data, 8'h01);
  endtask

  task automatic t_msix();
    msix_en = 1'b1;
    pulse_c();
    chk("R8 status quiet", {7'd0, pci_int_status}, 8'h00);
    chk("R8 pin quiet", {7'd0, intx_out}, 8'h00);
    do_read();
    chk("R10 read under msix", rd_data, 8'h02);
    msix_en = 1'b0; #1;
    chk("R10 no stale status", {7'd0, pci_int_status}, 8'h00);
    chk("R10 no stale pin", {7'd0, intx_out}, 8'h00);
  endtask

  task automatic t_race();
    pulse_q();
    rd_en = 1'b1; cfg_evt = 1'b1; tick(); rd_en = 1'b0; cfg_evt = 1'b0;
    chk("R9 old value", rd_data, 8'h01);
    chk("R9 pin stays", {7'd0, intx_out}, 8'h01);
    do_read();
    chk("R9 event kept", rd_data, 8'h02);
    pulse_q();
    rd_en = 1'b1; queue_evt = 1'b1; tick(); rd_en = 1'b0; queue_evt = 1'b0;
    chk("R9 same bit old", rd_data, 8'h01);
    do_read();
    chk("R9 same bit kept", rd_data, 8'h01);
  endtask

  task automatic t_hold();
    pulse_c();
    do_read();
    chk("R11 read value", rd_data, 8'h02);
    pulse_q(); tick(); pulse_c();
    chk("R11 hold", rd_data, 8'h02);
    do_read();
    chk("R11 next read", rd_data, 8'h03);
  endtask

  initial begin
    t_reset();
    t_queue();
    t_cfg();
    t_sticky();
    t_mask();
    t_msix();
    t_race();
    t_hold();
    tick();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #250000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule